// File: doc/BRIEF.md
# Serially Loaded Sigma-Delta DAC

This block is a write-only serial slave feeding a one-bit sigma-delta converter. A host frames each write by holding a select line high. While select is high, the host shifts data in on the falling edges of a serial clock, most significant bit first. The number of serial clock falls inside the frame picks the target. Eight falls load an 8-bit mode register. Sixteen falls load the converter code. A frame of any other length is dropped.

A first-order accumulator turns the code into a one-bit stream. Each output bit occupies a slot of two system clocks. In non-return-to-zero format a 1 holds the output high for the whole slot. In return-to-zero format a 1 drives the output high for the first half of the slot only, so the duty can reach at most half of full scale. A low-resolution mode takes a 14-bit code from the low bits of a 16-bit frame and left-aligns it, so full scale is the same in both modes.

A fault flag latches an alarm. While the alarm is latched, the output copies an external jump level. The alarm clears on a rising edge of the kick input or on reset.

Top module: `spi_sd_dac`

## Requirements
- R1: After reset the mode register reads 0x00, the code is 0, and `dacOut` stays low.
- R2: A frame with exactly 8 serial clock falls loads the shifted bits, MSB first, into the mode register. The whole register appears on `modeOut`: bit 0 is the resolution, bit 5 the kick source, bit 6 the output format, and bit 7 the receive idle polarity.
- R3: A frame with exactly 16 falls loads the converter code. A frame of any other length changes neither the mode register nor the code.
- R4: With mode bit 0 = 1 the code is 16 bits. Over 256 slots the number of 1 bits is within one of code/256.
- R5: With mode bit 0 = 0 only frame bits 13..0 form the code, and frame bits 15..14 are ignored. The 14-bit code is scaled as code×4 on the 16-bit scale.
- R6: With mode bit 6 = 1 (non-return-to-zero), a 1 bit holds `dacOut` high for both clocks of its slot.
- R7: With mode bit 6 = 0 (return-to-zero), a 1 bit holds `dacOut` high for only the first clock of its slot. `dacOut` is never high for two clocks in a row.
- R8: A high `faultIn` latches an alarm one clock later. While the alarm is latched, `dacOut` equals `jumpIn`. The alarm stays latched after `faultIn` drops and clears on a synchronised rising edge of `kickIn` or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclkIn | input | 1 | Serial clock, asynchronous |
| sdataIn | input | 1 | Serial data, sampled on serial clock falls |
| frameSel | input | 1 | Frame select, high during a frame |
| kickIn | input | 1 | Kick; a rising edge clears the alarm |
| faultIn | input | 1 | Fault flag, synchronous to clk |
| jumpIn | input | 1 | Alarm level for the output |
| modeOut | output | 8 | Mode register contents |
| dacOut | output | 1 | One-bit modulator output |

## Verification
The converter is loaded with mid-scale, full-scale, zero and random codes in both resolutions and both output formats. The high time over a 512-clock window separates the two resolutions and the two formats. The longest high run separates the two formats as well. A 14-bit frame with its top two bits set shows whether those bits are really ignored. Frames of 12 and 20 clocks check that only the two legal lengths take effect. The alarm is driven with both jump levels, then released by a kick and later by reset, to show that the latch holds and that both paths clear it.

// File: rtl/sddac_pkg.sv
package sddac_pkg;
  localparam int MODE_W       = 8;
  localparam int CODE_W       = 16;
  localparam int LOW_RES_W    = 14;
  localparam int MODE_RES_BIT = 0;
  localparam int MODE_FMT_BIT = 6;

  typedef struct packed {
    logic              loadMode;
    logic              loadCode;
    logic              kickRise;
    logic [CODE_W-1:0] word;
  } strobe_t;
endpackage

// File: rtl/sddac_ctrl.sv
module sddac_ctrl
  import sddac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkIn,
  input  logic    sdataIn,
  input  logic    frameSel,
  input  logic    kickIn,
  output strobe_t strobeOut
);
  localparam int CNT_W = $clog2(CODE_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CODE_W + 1);
  localparam logic [CNT_W-1:0] MODE_LEN = CNT_W'(MODE_W);
  localparam logic [CNT_W-1:0] CODE_LEN = CNT_W'(CODE_W);

  logic [SYNC_STAGES-1:0] sclkPipe, dataPipe, selPipe, kickPipe;
  logic sclkDly, selDly, kickDly;
  logic sclkS, dataS, selS, kickS;
  logic sclkFall, selRise, selFall;
  logic [CNT_W-1:0]  bitCount;
  logic [CODE_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPipe <= '0; dataPipe <= '0; selPipe <= '0; kickPipe <= '0;
      sclkDly  <= 1'b0; selDly <= 1'b0; kickDly <= 1'b0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclkIn};
      dataPipe <= {dataPipe[SYNC_STAGES-2:0], sdataIn};
      selPipe  <= {selPipe[SYNC_STAGES-2:0], frameSel};
      kickPipe <= {kickPipe[SYNC_STAGES-2:0], kickIn};
      sclkDly  <= sclkS;
      selDly   <= selS;
      kickDly  <= kickS;
    end
  end

  assign sclkS    = sclkPipe[SYNC_STAGES-1];
  assign dataS    = dataPipe[SYNC_STAGES-1];
  assign selS     = selPipe[SYNC_STAGES-1];
  assign kickS    = kickPipe[SYNC_STAGES-1];
  assign sclkFall = sclkDly & ~sclkS;
  assign selRise  = selS & ~selDly;
  assign selFall  = selDly & ~selS;

  // Frame bit counter saturates so over-long frames never alias to a legal length
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCount <= '0;
      shiftReg <= '0;
    end else if (selRise || selFall) begin
      bitCount <= '0;
    end else if (selS && sclkFall) begin
      shiftReg <= {shiftReg[CODE_W-2:0], dataS};
      if (bitCount != CNT_SAT) bitCount <= bitCount + 1'b1;
    end
  end

  always_comb begin
    strobeOut.loadMode = selFall && (bitCount == MODE_LEN);
    strobeOut.loadCode = selFall && (bitCount == CODE_LEN);
    strobeOut.kickRise = kickS & ~kickDly;
    strobeOut.word     = shiftReg;
  end

  // R3
  count_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOut.loadMode || strobeOut.loadCode) |=> (bitCount == '0));
endmodule

// File: rtl/sddac_datapath.sv
module sddac_datapath
  import sddac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobeIn,
  input  logic              faultIn,
  input  logic              jumpIn,
  output logic [MODE_W-1:0] modeOut,
  output logic              dacOut
);
  localparam int PAD = CODE_W - LOW_RES_W;

  logic [MODE_W-1:0] modeReg;
  logic [CODE_W-1:0] codeReg, accReg, lowResCode;
  logic [CODE_W:0]   sum;
  logic slotPhase, bitReg, alarmLatched, modOut;

  generate
    if (PAD > 0) begin : g_pad
      assign lowResCode = {strobeIn.word[LOW_RES_W-1:0], {PAD{1'b0}}};
    end else begin : g_nopad
      assign lowResCode = strobeIn.word;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      codeReg <= '0;
    end else begin
      if (strobeIn.loadMode) modeReg <= strobeIn.word[MODE_W-1:0];
      if (strobeIn.loadCode)
        codeReg <= modeReg[MODE_RES_BIT] ? strobeIn.word : lowResCode;
    end
  end

  // First-order accumulator, one output bit per two-clock slot
  assign sum = {1'b0, accReg} + {1'b0, codeReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotPhase <= 1'b0;
      accReg    <= '0;
      bitReg    <= 1'b0;
    end else begin
      slotPhase <= ~slotPhase;
      if (slotPhase) begin
        accReg <= sum[CODE_W-1:0];
        bitReg <= sum[CODE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  alarmLatched <= 1'b0;
    else if (faultIn)           alarmLatched <= 1'b1;
    else if (strobeIn.kickRise) alarmLatched <= 1'b0;
  end

  assign modOut  = bitReg & (modeReg[MODE_FMT_BIT] | ~slotPhase);
  assign dacOut  = alarmLatched ? jumpIn : modOut;
  assign modeOut = modeReg;

  // R7
  rtz_single_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeReg[MODE_FMT_BIT] && !strobeIn.loadMode && modOut) |=> !modOut);
  // R6
  nrz_slot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[MODE_FMT_BIT] && !slotPhase && !strobeIn.loadMode) |=> $stable(modOut));
  // R8
  fault_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultIn |=> (dacOut == jumpIn));
  // R4
  zero_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeReg == '0 && slotPhase) |=> !bitReg);
endmodule

// File: rtl/spi_sd_dac.sv
module spi_sd_dac
  import sddac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       sdataIn,
  input  logic       frameSel,
  input  logic       kickIn,
  input  logic       faultIn,
  input  logic       jumpIn,
  output logic [7:0] modeOut,
  output logic       dacOut
);
  strobe_t strobe;
  logic [MODE_W-1:0] modeBits;

  sddac_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdataIn(sdataIn),
    .frameSel(frameSel), .kickIn(kickIn), .strobeOut(strobe)
  );

  sddac_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobeIn(strobe), .faultIn(faultIn),
    .jumpIn(jumpIn), .modeOut(modeBits), .dacOut(dacOut)
  );

  assign modeOut = modeBits;
endmodule

// File: tb/test_spi_sd_dac.sv
module test_spi_sd_dac;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0, sdataIn = 1'b0, frameSel = 1'b0;
  logic kickIn = 1'b0, faultIn = 1'b0, jumpIn = 1'b0;
  logic [7:0] modeOut;
  logic dacOut;

  int checkCnt = 0, failCnt = 0;
  int highCnt, maxRun;
  bit done = 0;

  always #10 clk = ~clk;

  spi_sd_dac i_spi_sd_dac (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdataIn(sdataIn),
    .frameSel(frameSel), .kickIn(kickIn), .faultIn(faultIn),
    .jumpIn(jumpIn), .modeOut(modeOut), .dacOut(dacOut)
  );

  function automatic int expHigh(logic [15:0] v, bit res16, bit nrz);
    int c;
    c = res16 ? int'(v) : (int'(v[13:0]) << 2);
    return nrz ? 2 * (c >> 8) : (c >> 8);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkNear(int act, int exp, int tol, string tag);
    check((act >= exp - tol) && (act <= exp + tol), tag, act, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(int n, logic [31:0] v);
    @(negedge clk); frameSel = 1'b1; idle(4);
    for (int i = n - 1; i >= 0; i--) begin
      sclkIn = 1'b1; sdataIn = v[i]; idle(4);
      sclkIn = 1'b0; idle(4);
    end
    frameSel = 1'b0; idle(8);
  endtask

  task automatic measure(int n);
    int run;
    highCnt = 0; maxRun = 0; run = 0;
    repeat (n) begin
      @(negedge clk);
      if (dacOut) begin
        highCnt++; run++;
        if (run > maxRun) maxRun = run;
      end else run = 0;
    end
  endtask

  task automatic tryCode(logic [15:0] v, bit res16, bit nrz, string tag);
    sendFrame(8, {25'd0, nrz, 5'd0, res16});
    sendFrame(16, {16'd0, v});
    idle(8);
    measure(512);
    checkNear(highCnt, expHigh(v, res16, nrz), nrz ? 4 : 2, tag);
    if (!nrz) check(maxRun <= 1, {tag, " R7 run"}, maxRun, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    bit rres, rnrz;
    void'($urandom(32'd4242));
    idle(4);
    rstN = 1'b1;
    idle(4);
    // R1 reset state
    check(modeOut == 8'h00, "R1 mode", modeOut, 0);
    measure(64);
    check(highCnt == 0, "R1 dac", highCnt, 0);

    // R2 mode load and field export
    sendFrame(8, 32'hA1);
    check(modeOut == 8'hA1, "R2 mode A1", modeOut, 8'hA1);
    check(modeOut[5] && modeOut[7], "R2 bits5/7", modeOut, 8'hA1);
    sendFrame(8, 32'h41);
    check(modeOut == 8'h41, "R2 mode 41", modeOut, 8'h41);

    // R4 R6 16-bit NRZ mid scale
    sendFrame(16, 32'h8000); idle(8);
    measure(512);
    checkNear(highCnt, 256, 4, "R4 R6 nrz mid");
    check(maxRun >= 2, "R6 run", maxRun, 2);

    // R7 return-to-zero mid and full scale
    tryCode(16'h8000, 1, 0, "R7 rtz mid");
    tryCode(16'hFFFF, 1, 0, "R7 rtz full");
    check(highCnt <= 256, "R7 half duty", highCnt, 256);

    // R5 14-bit, top frame bits ignored
    tryCode(16'hD000, 0, 1, "R5 14b nrz");
    tryCode(16'h3000, 0, 1, "R5 14b nrz full-ish");

    // R3 illegal lengths ignored
    sendFrame(8, 32'h41);
    sendFrame(16, 32'h4000); idle(8);
    sendFrame(12, 32'hFFF);
    sendFrame(20, 32'hFFFFF);
    check(modeOut == 8'h41, "R3 mode kept", modeOut, 8'h41);
    measure(512);
    checkNear(highCnt, 128, 4, "R3 code kept");

    // R4 R5 random
    for (int k = 0; k < 8; k++) begin
      rv = 16'($urandom);
      rres = 1'($urandom);
      rnrz = 1'($urandom);
      tryCode(rv, rres, rnrz, rres ? "R4 random" : "R5 random");
    end

    // R8 alarm
    sendFrame(8, 32'h41);
    sendFrame(16, 32'h0000); idle(8);
    @(negedge clk); jumpIn = 1'b1; faultIn = 1'b1;
    @(negedge clk);
    check(dacOut == 1'b1, "R8 jump high", dacOut, 1);
    faultIn = 1'b0; idle(5);
    check(dacOut == 1'b1, "R8 hold", dacOut, 1);
    jumpIn = 1'b0; @(negedge clk);
    check(dacOut == 1'b0, "R8 jump low", dacOut, 0);
    jumpIn = 1'b1; @(negedge clk);
    kickIn = 1'b1; idle(6);
    kickIn = 1'b0; idle(2);
    measure(32);
    check(highCnt == 0, "R8 kick clear", highCnt, 0);
    faultIn = 1'b1; @(negedge clk); faultIn = 1'b0; idle(3);
    check(dacOut == 1'b1, "R8 relatch", dacOut, 1);
    rstN = 1'b0; idle(3); rstN = 1'b1; idle(2);
    measure(32);
    check(highCnt == 0, "R8 R1 reset clears", highCnt, 0);
    check(modeOut == 8'h00, "R1 mode after reset", modeOut, 0);

    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule